// File: doc/BRIEF.md
# Serial Video Packet Framer

The framer turns a parallel pixel stream (a pixel word plus frame-valid and line-valid flags) into a single serial bit line for a differential link. Each pixel or control word is wrapped in a packet. The packet opens with a 1 start bit and closes with a 0 stop bit, and it leaves least significant bit first. A bit-rate enable paces the packets. The enable pulses packet-length times per pixel period, so every packet slot takes exactly one input sample.

Timing is carried in the data. The codes 0 to 3 are kept for markers. Each marker goes out as an escape word of all ones followed by its code. Real pixels below 4 are raised to 4, so the receiver cannot read them as codes. In dual-sensor mode, the upper bits of a primary and a secondary pixel share one wider packet. Slots that carry no word are sent as all-zero slots, so the line rests at the stop level.

Top module: `svp_framer`

## Requirements
- R1: In single mode, a packet is 12 bits. Bit 0 is 1, bits 1 to 10 are the 10-bit field with its LSB first, and bit 11 is 0.
- R2: In dual mode (`stereo_en`=1), a packet is 18 bits. Bit 0 is 1, bits 1 to 8 hold the primary field `pix_m[9:2]` with its LSB first, bits 9 to 16 hold the secondary field `pix_s[9:2]`, and bit 17 is 0.
- R3: In single mode, a pixel below 4 is sent as 4 and any other value is sent unchanged, 1023 included. In dual mode, an 8-bit field below 4 is sent as 4. A field value below 4 only ever follows an escape word.
- R4: Before the first pixel of a line, two words are sent: escape, then code 1. The escape is 1023 in single mode and 255 in both fields in dual mode. In dual mode a code fills both fields.
- R5: The first line after reset, or after any sample with `frame_vld`=0, uses code 0 in place of code 1.
- R6: After the last pixel of a line, two words are sent: escape, then a code. The code is 2 if `frame_vld` is still 1 in the sample after the last pixel, and 3 if it is 0.
- R7: During reset, and in slots that carry no word, `ser_out` is 0.
- R8: While `shift_en` is 0, `ser_out` holds its value.

Inputs are sampled once per slot. The first pixel of a line goes out two slots after its sample. Lines must be separated by at least 4 samples with `line_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Bit-rate enable, one pulse per serial bit |
| stereo_en | input | 1 | Selects the 18-bit dual-sensor packet; change only in reset |
| frame_vld | input | 1 | Frame valid of the input stream |
| line_vld | input | 1 | Line valid; the sample carries a pixel |
| pix_m | input | 10 | Primary pixel |
| pix_s | input | 10 | Secondary pixel (dual mode only) |
| ser_out | output | 1 | Serial packet stream |

## Verification
A wrong slot counter shows up within one packet. The receiver then finds a nonzero stop bit, or data shifted by one position, on the very next word. A wrong valid-history bit moves or drops an escape/code pair. The scoreboard sees this as a mismatch at the first marker of the next line. A first-line flag that fails to clear or to set turns the code 0/1 wrong, and this appears at the start of the next line or frame.

// File: rtl/svp_framer.sv
module svp_framer #(
  parameter int PIX_W = 10,
  parameter int FLD_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             stereo_en,
  input  logic             frame_vld,
  input  logic             line_vld,
  input  logic [PIX_W-1:0] pix_m,
  input  logic [PIX_W-1:0] pix_s,
  output logic             ser_out
);
  localparam int MONO_LEN = PIX_W + 2;
  localparam int DUO_LEN  = 2*FLD_W + 2;
  localparam int PKT_MAX  = (MONO_LEN > DUO_LEN) ? MONO_LEN : DUO_LEN;
  localparam int CW       = $clog2(PKT_MAX);
  localparam int NCODES   = 4;
  localparam int SHR      = PIX_W - FLD_W;

  typedef enum logic [1:0] {K_IDLE, K_ESC, K_CODE, K_PIX} kind_t;

  logic [CW-1:0]      cnt;
  logic [PKT_MAX-1:0] shreg, next_pkt;
  logic [3:0]         lv_p;
  logic [2:0]         fv_p;
  logic [PIX_W-1:0]   pm1, pm2, ps1, ps2;
  logic               first_pend;
  kind_t              kind;
  logic [1:0]         code;
  logic [PIX_W-1:0]   mono_fld;
  logic [FLD_W-1:0]   fld_m, fld_s;

  function automatic logic [PIX_W-1:0] lift_w(input logic [PIX_W-1:0] v);
    return (v < PIX_W'(NCODES)) ? PIX_W'(NCODES) : v;
  endfunction

  function automatic logic [FLD_W-1:0] lift_f(input logic [PIX_W-1:0] v);
    return (v < PIX_W'(NCODES << SHR)) ? FLD_W'(NCODES) : v[PIX_W-1 -: FLD_W];
  endfunction

  always_comb begin
    kind = K_IDLE;
    code = 2'd1;
    if (lv_p[1])                    kind = K_PIX;
    else if (line_vld && !lv_p[0])  kind = K_ESC;
    else if (lv_p[0]) begin
      kind = K_CODE;
      code = first_pend ? 2'd0 : 2'd1;
    end
    else if (lv_p[2])               kind = K_ESC;
    else if (lv_p[3]) begin
      kind = K_CODE;
      code = fv_p[2] ? 2'd2 : 2'd3;
    end
  end

  always_comb begin
    case (kind)
      K_PIX:  begin mono_fld = lift_w(pm2); fld_m = lift_f(pm2); fld_s = lift_f(ps2); end
      K_ESC:  begin mono_fld = '1; fld_m = '1; fld_s = '1; end
      K_CODE: begin mono_fld = PIX_W'(code); fld_m = FLD_W'(code); fld_s = FLD_W'(code); end
      default: begin mono_fld = '0; fld_m = '0; fld_s = '0; end
    endcase
  end

  assign next_pkt = (kind == K_IDLE) ? '0 :
                    stereo_en ? PKT_MAX'({1'b0, fld_s, fld_m, 1'b1}) :
                                PKT_MAX'({1'b0, mono_fld, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      shreg      <= '0;
      lv_p       <= '0;
      fv_p       <= '0;
      pm1        <= '0;
      pm2        <= '0;
      ps1        <= '0;
      ps2        <= '0;
      first_pend <= 1'b1;
    end else if (shift_en) begin
      if (cnt == '0) begin
        cnt   <= stereo_en ? CW'(DUO_LEN-1) : CW'(MONO_LEN-1);
        shreg <= next_pkt;
        lv_p  <= {lv_p[2:0], line_vld};
        fv_p  <= {fv_p[1:0], frame_vld};
        pm1   <= pix_m;
        pm2   <= pm1;
        ps1   <= pix_s;
        ps2   <= ps1;
        if (!frame_vld)                 first_pend <= 1'b1;
        else if (lv_p[0] && !lv_p[1])   first_pend <= 1'b0;
      end else begin
        cnt   <= cnt - 1'b1;
        shreg <= shreg >> 1;
      end
    end
  end

  assign ser_out = shreg[0];
endmodule

// File: rtl/svp_framer_chk.sv
module svp_framer_chk #(
  parameter int PIX_W = 10,
  parameter int FLD_W = 8
)(
  input logic clk,
  input logic rst_n,
  input logic shift_en,
  input logic stereo_en,
  input logic ser_out
);
  localparam int MONO_LEN = PIX_W + 2;
  localparam int DUO_LEN  = 2*FLD_W + 2;
  localparam int PKT_MAX  = (MONO_LEN > DUO_LEN) ? MONO_LEN : DUO_LEN;
  localparam int CW       = $clog2(PKT_MAX);

  logic               started, done, prev_esc, is_esc;
  logic [CW-1:0]      pos, last;
  logic [PKT_MAX-1:0] acc;
  logic [PIX_W-1:0]   fld;

  assign last   = stereo_en ? CW'(DUO_LEN-1) : CW'(MONO_LEN-1);
  assign fld    = stereo_en ? PIX_W'(acc[FLD_W:1]) : acc[PIX_W:1];
  assign is_esc = stereo_en ? (acc[FLD_W:1] == '1) : (acc[PIX_W:1] == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      done     <= 1'b0;
      prev_esc <= 1'b0;
      pos      <= '0;
      acc      <= '0;
    end else begin
      done <= 1'b0;
      if (done) prev_esc <= acc[0] && is_esc;
      if (shift_en) begin
        started <= 1'b1;
        if (started) begin
          acc[pos] <= ser_out;
          done     <= (pos == last);
          pos      <= (pos == last) ? '0 : pos + 1'b1;
        end
      end
    end
  end

  // R1 R2
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !acc[last]);

  // R3
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acc[0] && fld < PIX_W'(4)) |-> prev_esc);

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !ser_out);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(ser_out));
endmodule

bind svp_framer svp_framer_chk #(.PIX_W(PIX_W), .FLD_W(FLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
  .stereo_en(stereo_en), .ser_out(ser_out));

// File: tb/tb_svp_framer.sv
module tb_svp_framer;
  logic clk = 1'b0, rst_n = 1'b0, shift_en = 1'b0, stereo_en = 1'b0;
  logic frame_vld = 1'b0, line_vld = 1'b0;
  logic [9:0] pix_m = '0, pix_s = '0;
  logic ser_out;

  int errors = 0, checks = 0;
  bit run_done = 0;
  bit stereo = 0;
  int plen = 12;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  svp_framer dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .stereo_en(stereo_en),
    .frame_vld(frame_vld), .line_vld(line_vld), .pix_m(pix_m), .pix_s(pix_s),
    .ser_out(ser_out));

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int lift(int v);
    return (v < 4) ? 4 : v;
  endfunction

  function automatic int exp_pix(int m, int s);
    return stereo ? ((lift(s >> 2) << 8) | lift(m >> 2)) : lift(m);
  endfunction

  function automatic int exp_ctl(int c);
    return stereo ? ((c << 8) | c) : c;
  endfunction

  function automatic int esc_word();
    return stereo ? 16'hFFFF : 1023;
  endfunction

  function automatic int pix_val(int k);
    case (k % 8)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 4;
      4: return 1023;
      5: return 13;
      6: return 2;
      default: return 600 + k;
    endcase
  endfunction

  task automatic push(int v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: deserialize packets and compare against the scoreboard
  initial begin
    bit en, busy;
    int nb, word;
    busy = 0; nb = 0; word = 0;
    forever begin
      @(posedge clk);
      en = shift_en && rst_n;
      @(negedge clk);
      if (en) begin
        if (!busy) begin
          if (ser_out) begin busy = 1; nb = 1; word = 0; end
        end else if (nb < plen - 1) begin
          word = word | (int'(ser_out) << (nb - 1));
          nb++;
        end else begin
          busy = 0;
          check(ser_out == 1'b0, stereo ? "R2 stop bit" : "R1 stop bit", ser_out, 0);
          if (exp_q.size() == 0) begin
            check(0, "R4 unexpected packet", word, -1);
          end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(word == e, t, word, e);
          end
        end
      end
    end
  end

  task automatic put(bit fv, bit lv, int m, int s, bit stall, bit idle_chk);
    frame_vld = fv;
    line_vld  = lv;
    pix_m     = 10'(m);
    pix_s     = 10'(s);
    for (int i = 0; i < plen; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (idle_chk) check(ser_out == 1'b0, "R7 idle slot", ser_out, 0);
      if (stall && i == 4) begin
        logic held;
        held = ser_out;
        shift_en = 1'b0;
        repeat (3) begin
          @(negedge clk);
          check(ser_out == held, "R8 hold", ser_out, held);
        end
        shift_en = 1'b1;
      end
    end
  endtask

  task automatic send_line(int n, int base, bit first, bit endf, bit stall);
    push(esc_word(), "R4 line escape");
    push(exp_ctl(first ? 0 : 1), first ? "R5 frame start code" : "R4 line start code");
    for (int i = 0; i < n; i++) begin
      int m, s;
      m = pix_val(base + i);
      s = pix_val(base + i + 3);
      push(exp_pix(m, s), stereo ? "R2 R3 dual pixel" : "R1 R3 pixel");
      put(1'b1, 1'b1, m, s, stall && i == 1, 1'b0);
    end
    push(esc_word(), "R6 end escape");
    push(exp_ctl(endf ? 3 : 2), "R6 end code");
    repeat (5) put(!endf, 1'b0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(bit dual);
    @(negedge clk);
    rst_n = 1'b0;
    shift_en = 1'b0;
    stereo = dual;
    stereo_en = dual;
    plen = dual ? 18 : 12;
    frame_vld = 1'b0;
    line_vld = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_out == 1'b0, "R7 reset", ser_out, 0);
    rst_n = 1'b1;
    shift_en = 1'b1;
  endtask

  initial begin
    do_reset(1'b0);
    repeat (2) put(1'b0, 1'b0, 0, 0, 1'b0, 1'b1);
    send_line(6, 0, 1'b1, 1'b0, 1'b1);
    send_line(8, 8, 1'b0, 1'b1, 1'b0);
    send_line(3, 2, 1'b1, 1'b1, 1'b0);
    repeat (3) put(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    check(exp_q.size() == 0, "R6 single mode drained", exp_q.size(), 0);

    do_reset(1'b1);
    repeat (2) put(1'b0, 1'b0, 0, 0, 1'b0, 1'b1);
    send_line(5, 0, 1'b1, 1'b0, 1'b1);
    send_line(8, 4, 1'b0, 1'b1, 1'b0);
    repeat (3) put(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    check(exp_q.size() == 0, "R6 dual mode drained", exp_q.size(), 0);
    run_done = 1;
  end

  initial begin
    fork
      wait (run_done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule